// File: doc/BRIEF.md
# Reloadable-Coefficient FIR Filter

This block is a finite-impulse-response filter for a sampled pulse stream. It accepts one signed sample per clock and produces one full-precision filtered sample per clock, z(n) = sum over i of k_i * y(n-i), for i from 0 to TAPS-1. A build parameter selects the structure. The direct structure keeps a line of delayed samples and sums their products in one cycle. The transposed structure multiplies each new sample by every coefficient and passes partial sums down a chain of registered adders. Both structures give the same result with the same latency.

The coefficients are not fixed in the design. While `load_i` is high, one coefficient per clock enters on `coef_i` and the coefficient chain shifts by one tap. The values are presented highest index first, so after TAPS load cycles each value sits at its own tap. Sample processing is frozen during loading. The output valid flag stays low until enough new samples have arrived to fill the whole filter window. The tap count, the sample width and the coefficient width are separate parameters. The block is intended for tap counts of 7, 20 and 40.

Top module: `reloadable_fir`

## Requirements
- R1: While `rst_ni` is low and after its release, `valid_o` is 0 and `z_o` is 0 until the first filtered output is produced.
- R2: At each rising edge with `load_i` high, `coef_i` enters the chain and every stored coefficient moves one tap up. The value presented TAPS cycles before the end of the load is k(TAPS-1), and the value presented last is k0.
- R3: At each rising edge with `load_i` high, `sample_i` is ignored, `z_o` keeps its value and `valid_o` goes to 0.
- R4: `valid_o` is 1 after an edge only if, at that edge, `load_i` is low and TAPS samples were already accepted after the last reset or the last load cycle.
- R5: `z_o` after an edge with `load_i` low equals sum k_i * y(m-i) for i from 0 to TAPS-1, where y(m) is the most recent sample accepted before that edge. A sample therefore reaches `z_o` one clock after the edge that accepts it.
- R6: `z_o` is the exact two's complement sum on DATA_W+COEF_W+clog2(TAPS) bits. It does not overflow for any sample and coefficient values, including all most-negative values.
- R7: Reset clears the sample and sum registers but leaves the coefficients unchanged, so filtering resumes after reset without a reload.
- R8: A load held for more than TAPS cycles keeps only the last TAPS values presented, in the order of R2.
- R9: The direct and transposed structures produce identical `z_o` and `valid_o` sequences for identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; coefficients not affected |
| load_i | input | 1 | Coefficient load enable; freezes sample processing |
| coef_i | input | COEF_W | Signed coefficient, highest index first |
| sample_i | input | DATA_W | Signed input sample y(n) |
| z_o | output | DATA_W+COEF_W+clog2(TAPS) | Signed filtered sample z(n) |
| valid_o | output | 1 | High when `z_o` covers a full window of new samples |

## Verification
The assertions on coefficient and sample stability assume that the coefficient chain holds known values once reset is released. The bench keeps `load_i` high throughout the first reset so that the chain is flushed to zeros, and it loads real coefficients before it drops `load_i`. The valid-source and freeze properties assume that `load_i` is driven away from the clock edge. The stimulus mixes random samples with random reloads of TAPS or more cycles, plus extreme-value runs. It applies a second reset with `load_i` low, so that the chain keeps its coefficients across that reset.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic {FORM_DIRECT, FORM_TRANSPOSED} fir_form_e;

  function automatic int acc_w(int data_w, int coef_w, int taps);
    return data_w + coef_w + $clog2(taps);
  endfunction
endpackage

// File: rtl/fir_coef_chain.sv
module fir_coef_chain #(
  parameter int TAPS   = 7,
  parameter int COEF_W = 10
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [COEF_W-1:0]            coef_i,
  output logic [TAPS-1:0][COEF_W-1:0]  coef_o
);
  logic [TAPS-1:0][COEF_W-1:0] coef_q;

  // no reset: coefficients survive rst_ni
  always_ff @(posedge clk_i) begin
    if (load_i) coef_q <= {coef_q[TAPS-2:0], coef_i};
  end

  assign coef_o = coef_q;

  // R2
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(coef_q));
endmodule

// File: rtl/fir_direct.sv
module fir_direct #(
  parameter int TAPS   = 7,
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int ACC_W  = 25
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [DATA_W-1:0]            sample_i,
  input  logic [TAPS-1:0][COEF_W-1:0]  coef_i,
  output logic [ACC_W-1:0]             sum_o
);
  logic [TAPS-1:0][DATA_W-1:0] x_q;
  logic signed [ACC_W-1:0]     prod [TAPS];
  logic signed [ACC_W-1:0]     sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      x_q <= '0;
    else if (!load_i) x_q <= {x_q[TAPS-2:0], sample_i};
  end

  for (genvar i = 0; i < TAPS; i++) begin : g_mul
    assign prod[i] = ACC_W'($signed(x_q[i])) * ACC_W'($signed(coef_i[i]));
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < TAPS; i++) sum = sum + prod[i];
  end

  assign sum_o = sum;

  // R3
  line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> $stable(x_q));
endmodule

// File: rtl/fir_transposed.sv
module fir_transposed #(
  parameter int TAPS   = 7,
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  parameter int ACC_W  = 25
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         load_i,
  input  logic [DATA_W-1:0]            sample_i,
  input  logic [TAPS-1:0][COEF_W-1:0]  coef_i,
  output logic [ACC_W-1:0]             sum_o
);
  logic [TAPS-1:0][ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0]    prod [TAPS];

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign prod[i] = ACC_W'($signed(sample_i)) * ACC_W'($signed(coef_i[i]));
    if (i == TAPS - 1) begin : g_end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      acc_q[i] <= '0;
        else if (!load_i) acc_q[i] <= prod[i];
      end
    end else begin : g_mid
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      acc_q[i] <= '0;
        else if (!load_i) acc_q[i] <= $signed(acc_q[i+1]) + prod[i];
      end
    end
  end

  assign sum_o = acc_q[0];

  // R3
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> $stable(acc_q));
endmodule

// File: rtl/fir_valid_ctrl.sv
module fir_valid_ctrl #(
  parameter int TAPS = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic valid_o
);
  localparam int CNT_W = $clog2(TAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(TAPS);

  logic [CNT_W-1:0] cnt_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= (cnt_q == FULL);
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign valid_o = valid_q;

  // R4
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  // R4
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(!load_i));
endmodule

// File: rtl/reloadable_fir.sv
module reloadable_fir #(
  parameter fir_pkg::fir_form_e FORM = fir_pkg::FORM_DIRECT,
  parameter int TAPS   = 7,
  parameter int DATA_W = 12,
  parameter int COEF_W = 10,
  localparam int ACC_W = fir_pkg::acc_w(DATA_W, COEF_W, TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [COEF_W-1:0] coef_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic [ACC_W-1:0]  z_o,
  output logic              valid_o
);
  logic [TAPS-1:0][COEF_W-1:0] coef;
  logic [ACC_W-1:0]            sum;
  logic [ACC_W-1:0]            z_q;

  fir_coef_chain #(.TAPS(TAPS), .COEF_W(COEF_W)) i_coef_chain (
    .clk_i, .rst_ni, .load_i, .coef_i, .coef_o(coef)
  );

  if (FORM == fir_pkg::FORM_DIRECT) begin : g_direct
    fir_direct #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_core (
      .clk_i, .rst_ni, .load_i, .sample_i, .coef_i(coef), .sum_o(sum)
    );
  end else begin : g_transposed
    fir_transposed #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) i_core (
      .clk_i, .rst_ni, .load_i, .sample_i, .coef_i(coef), .sum_o(sum)
    );
  end

  fir_valid_ctrl #(.TAPS(TAPS)) i_valid_ctrl (
    .clk_i, .rst_ni, .load_i, .valid_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      z_q <= '0;
    else if (!load_i) z_q <= sum;
  end

  assign z_o = z_q;

  // R3
  load_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> ($stable(z_o) && !valid_o));
endmodule

// File: tb/test_reloadable_fir.sv
module test_reloadable_fir;
  localparam int L  = 7;
  localparam int DW = 12;
  localparam int CW = 10;
  localparam int AW = DW + CW + $clog2(L);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic load_i = 1'b1;
  logic [CW-1:0] coef_i = '0;
  logic [DW-1:0] sample_i = '0;
  logic [AW-1:0] zd, zt;
  logic vd, vt;

  always #2.5 clk_i = ~clk_i;

  reloadable_fir #(.FORM(fir_pkg::FORM_DIRECT), .TAPS(L), .DATA_W(DW), .COEF_W(CW)) i_reloadable_fir (
    .clk_i, .rst_ni, .load_i, .coef_i, .sample_i, .z_o(zd), .valid_o(vd)
  );
  reloadable_fir #(.FORM(fir_pkg::FORM_TRANSPOSED), .TAPS(L), .DATA_W(DW), .COEF_W(CW)) i_reloadable_fir_t (
    .clk_i, .rst_ni, .load_i, .coef_i, .sample_i, .z_o(zt), .valid_o(vt)
  );

  int total = 0, bad = 0, cnt = 0;
  longint kb [L];
  longint hist [L];
  bit exp_valid;
  longint exp_z;
  bit done = 1'b0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint conv();
    longint s = 0;
    for (int i = 0; i < L; i++) s += kb[i] * hist[i];
    return s;
  endfunction

  // one clock: inputs driven after negedge, checked at next negedge
  task automatic cyc(bit ld, longint c, longint s);
    longint zd_old = longint'($signed(zd));
    longint zt_old = longint'($signed(zt));
    load_i = ld; coef_i = CW'(c); sample_i = DW'(s);
    @(posedge clk_i);
    if (ld) begin
      for (int i = L - 1; i > 0; i--) kb[i] = kb[i-1];
      kb[0] = c; cnt = 0; exp_valid = 1'b0;
    end else begin
      exp_valid = (cnt == L);
      exp_z = conv();
      for (int i = L - 1; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = s;
      if (cnt < L) cnt++;
    end
    @(negedge clk_i);
    chk("R4 valid direct", longint'(vd), longint'(exp_valid));
    chk("R9 valid transposed", longint'(vt), longint'(exp_valid));
    if (ld) begin
      chk("R3 hold direct", longint'($signed(zd)), zd_old);
      chk("R3 hold transposed", longint'($signed(zt)), zt_old);
    end else if (exp_valid) begin
      chk("R5 z direct", longint'($signed(zd)), exp_z);
      chk("R9 z transposed", longint'($signed(zt)), exp_z);
    end
  endtask

  task automatic load_set(longint v [L]);
    for (int i = L - 1; i >= 0; i--) cyc(1'b1, v[i], longint'($signed(DW'($urandom))));
  endtask

  function automatic longint rnd_s();
    return longint'($signed(DW'($urandom)));
  endfunction
  function automatic longint rnd_c();
    return longint'($signed(CW'($urandom)));
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    longint v [L];
    int unused;
    unused = $urandom(32'd4242);
    for (int i = 0; i < L; i++) begin kb[i] = 0; hist[i] = 0; end
    // first reset with load high flushes the chain to zero
    repeat (10) @(negedge clk_i);
    chk("R1 valid in reset", longint'(vd | vt), 0);
    chk("R1 z in reset", longint'($signed(zd)) + longint'($signed(zt)), 0);
    rst_ni = 1'b1;
    cyc(1'b1, 0, 0);
    chk("R1 z after reset", longint'($signed(zd)), 0);

    // R2: directed ramp coefficients, impulse response shows order
    for (int i = 0; i < L; i++) v[i] = i + 1;
    load_set(v);
    cyc(1'b0, 1, 1);
    for (int i = 0; i < 2 * L; i++) cyc(1'b0, 0, 0);
    // impulse: entered L new samples, then more zeros; recheck with fresh impulse
    cyc(1'b0, 0, 1);
    for (int i = 0; i < L; i++) begin
      cyc(1'b0, 0, 0);
      chk("R2 impulse tap", longint'($signed(zd)), longint'(i + 1));
    end

    // R8: long load, only last L values kept
    for (int i = 0; i < 3; i++) cyc(1'b1, 100 + i, rnd_s());
    for (int i = 0; i < L; i++) v[i] = rnd_c();
    load_set(v);
    for (int i = 0; i < 3 * L; i++) cyc(1'b0, 0, rnd_s());

    // R6: extreme values
    for (int i = 0; i < L; i++) v[i] = -(longint'(1) <<< (CW - 1));
    load_set(v);
    for (int i = 0; i < 2 * L; i++) cyc(1'b0, 0, -(longint'(1) <<< (DW - 1)));
    chk("R6 most negative", longint'($signed(zd)), longint'(L) * (longint'(1) <<< (DW + CW - 2)));
    for (int i = 0; i < 2 * L; i++) cyc(1'b0, 0, (longint'(1) <<< (DW - 1)) - 1);

    // random stream with random reloads
    for (int i = 0; i < L; i++) v[i] = rnd_c();
    load_set(v);
    for (int n = 0; n < 2000; n++) begin
      if ($urandom_range(0, 59) == 0) begin
        int extra = $urandom_range(0, 3);
        for (int j = 0; j < extra; j++) cyc(1'b1, rnd_c(), rnd_s());
        for (int i = 0; i < L; i++) v[i] = rnd_c();
        load_set(v);
      end else begin
        cyc(1'b0, 0, rnd_s());
      end
    end

    // R7: reset with load low keeps coefficients
    load_i = 1'b0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R7 valid cleared", longint'(vd | vt), 0);
    chk("R7 z cleared", longint'($signed(zt)), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < L; i++) hist[i] = 0;
    cnt = 0;
    for (int i = 0; i < 4 * L; i++) cyc(1'b0, 0, rnd_s());
    chk("R7 coefficients kept", longint'($signed(zd)), exp_z);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule